// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block gathers the interrupt requests of a PC-style serial port and turns them into a single interrupt line and an identification byte for the host. Four sources can raise a request: receive line errors, received data ready (with a character-timeout flavour), transmit holding register empty, and modem line changes. Each source has a bit in an internal pending vector and a matching bit in a four-bit enable register. The interrupt line is the OR of the enabled pending bits, and the identification byte reports the most urgent enabled source with a fixed code.

Neighbouring logic (receiver, transmitter, FIFO control, modem-line sampler) reports events as one-cycle set and clear pulses. The host reaches four registers of this block through a small read/write strobe interface: the enable register, the identification register, the receive error flags and the modem delta flags. Some accesses have side effects: reading the identification or status registers retires the matching source, and rewriting the enable register can re-arm the transmit-empty source. Read data is combinational from the current state; side effects take place at the clock edge on which the read strobe is high.

Top module: `uart_irq_ident`

## Requirements
- R1: `irq` is high exactly when at least one of the four pending sources (bit 0 data ready, bit 1 transmit empty, bit 2 line error, bit 3 modem change) has its enable bit set; a set pulse shows on `irq` after the next clock edge.
- R2: After reset the enable register reads 0, the identification byte reads 0x01 with FIFO mode off, and `irq` is low; identification bit 0 is 0 while `irq` is high and 1 otherwise.
- R3: Identification bits 3:1 name the highest enabled pending source: line error 011, then data ready 010, then transmit empty 001; a modem change alone gives 000, and bits 5:4 read 0.
- R4: A timeout pulse sets both the timeout and the data-ready pending bits; while data ready is the selected source and timeout is pending, bits 3:1 read 110. The timeout clear pulse drops only the timeout bit, and the data-ready clear pulse drops both.
- R5: A read strobe on the identification register (address 2) while its low nibble is 0x2 clears the transmit-empty pending bit; a read showing any other value leaves it pending.
- R6: A write to the enable register (address 1) with data bit 1 set while `thr_empty` is high sets the transmit-empty pending bit; with `thr_empty` low the write does not.
- R7: The enable register reads back its four written low bits at address 1 with bits 7:4 as zero.
- R8: Error pulses set sticky flags read at address 5 in bits 4:1 (bit 4 break, bit 3 framing, bit 2 parity, bit 1 overrun; other bits 0) and set the line-error source; a read strobe there while any flag is set clears all four flags and the source.
- R9: Modem change pulses set sticky delta flags read at address 6 in bits 3:0 and set the modem source; a read strobe there clears the deltas and the source.
- R10: With `fifo_en` high identification bits 7:6 read 11; with it low they read 00 and bit 3 is forced to 0, so a timeout shows as the plain data-ready code.
- R11: When a set pulse and a clear event reach the same source in one cycle, the source ends pending.
- R12: Reads of addresses 0, 3, 4 and 7 return 0, and writes to any address other than 1 leave the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode active (level) |
| thr_empty | input | 1 | Transmit holding register is empty (level) |
| set_rx_avail | input | 1 | Pulse: received data ready |
| clr_rx_avail | input | 1 | Pulse: received data drained |
| set_rx_timeout | input | 1 | Pulse: character timeout expired |
| clr_rx_timeout | input | 1 | Pulse: timeout condition withdrawn |
| set_thr_req | input | 1 | Pulse: transmit holding register became empty |
| clr_thr_req | input | 1 | Pulse: transmit holding register written |
| set_line_err | input | 4 | Pulse vector: break, framing, parity, overrun (bit 3 to 0) |
| set_modem_delta | input | 4 | Pulse vector: modem line change flags |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The main check sweeps every combination of the five pending conditions against all sixteen enable values in both FIFO modes, so the identification code is compared against an arithmetic model for each priority collision: line error masking data ready, data ready masking transmit empty, disabled sources being skipped, and timeout surfacing only with FIFO mode on. Directed sequences then separate the side effects: an identification read that must retire the transmit source against one that must not because a higher source is showing, an enable rewrite with and without the transmit register empty, and status reads that must clear their flags and sources. A simultaneous set and clear shows which of the two wins.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  // register interface geometry
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  // sources with an enable bit, plus the timeout qualifier
  localparam int NUM_SRC = 4;
  localparam int PEND_W  = NUM_SRC + 1;
  localparam int ERR_W   = 4;
  localparam int DELTA_W = 4;
  localparam int CODE_W  = 3;

  // pending / enable bit positions (shared with the enable register layout)
  localparam int SRC_RX    = 0;
  localparam int SRC_THR   = 1;
  localparam int SRC_LINE  = 2;
  localparam int SRC_MODEM = 3;
  localparam int SRC_TMO   = 4;

  // identification codes for bits 3:1
  localparam logic [CODE_W-1:0] CODE_LINE  = 3'b011;
  localparam logic [CODE_W-1:0] CODE_RX    = 3'b010;
  localparam logic [CODE_W-1:0] CODE_TMO   = 3'b110;
  localparam logic [CODE_W-1:0] CODE_THR   = 3'b001;
  localparam logic [CODE_W-1:0] CODE_MODEM = 3'b000;

  // host-visible register addresses
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_IDENT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINE   = 3'd5;
  localparam logic [ADDR_W-1:0] A_MODEM  = 3'd6;

  // identification low nibble that retires the transmit source on read
  localparam logic [3:0] IDENT_THR_NIB = {CODE_THR, 1'b0};

  typedef logic [PEND_W-1:0]  pend_t;
  typedef logic [NUM_SRC-1:0] enab_t;
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;
  logic         flag_en;

  // a new event in the clearing cycle survives the clear
  always_comb begin
    flag_d  = clr_i ? '0 : flag_q;
    flag_d  = flag_d | set_i;
    flag_en = clr_i | (|set_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign q_o = flag_q;
endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
  import uart_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pend_t set_i,
  input  pend_t clr_i,
  output pend_t pend_o
);
  pend_t pend_q;
  pend_t pend_d;
  logic  pend_en;

  for (genvar i = 0; i < PEND_W; i++) begin : g_src
    always_comb pend_d[i] = set_i[i] | (pend_q[i] & ~clr_i[i]);

    // R11: a set pulse always leaves the source pending
    assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> pend_o[i]);
  end

  always_comb pend_en = (|set_i) | (|clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  pend_t             pend_i,
  input  enab_t             enab_i,
  input  logic              fifo_en_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] ident_o
);
  enab_t             active;
  logic [CODE_W-1:0] code;
  logic              tmo_shown;

  always_comb begin
    active    = pend_i[NUM_SRC-1:0] & enab_i;
    tmo_shown = pend_i[SRC_TMO] & fifo_en_i;
    if (active[SRC_LINE]) begin
      code = CODE_LINE;
    end else if (active[SRC_RX]) begin
      code = tmo_shown ? CODE_TMO : CODE_RX;
    end else if (active[SRC_THR]) begin
      code = CODE_THR;
    end else begin
      code = CODE_MODEM;
    end
  end

  assign irq_o   = |active;
  assign ident_o = {{2{fifo_en_i}}, 2'b00, code, ~irq_o};
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              thr_empty,
  input  logic              set_rx_avail,
  input  logic              clr_rx_avail,
  input  logic              set_rx_timeout,
  input  logic              clr_rx_timeout,
  input  logic              set_thr_req,
  input  logic              clr_thr_req,
  input  logic [ERR_W-1:0]  set_line_err,
  input  logic [DELTA_W-1:0] set_modem_delta,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  // ---------------- reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_sync_q[1];

  // ---------------- access decode
  logic wr_enable, rd_ident, rd_line, rd_modem;

  always_comb begin
    wr_enable = reg_wr & (reg_addr == A_ENABLE);
    rd_ident  = reg_rd & (reg_addr == A_IDENT);
    rd_line   = reg_rd & (reg_addr == A_LINE);
    rd_modem  = reg_rd & (reg_addr == A_MODEM);
  end

  // ---------------- enable register
  enab_t enab_q;
  enab_t enab_d;

  always_comb enab_d = reg_wdata[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      enab_q <= '0;
    end else if (wr_enable) begin
      enab_q <= enab_d;
    end
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

  // ---------------- sticky status flags
  logic [ERR_W-1:0]   line_flags;
  logic [DELTA_W-1:0] modem_flags;
  logic               line_clr;

  always_comb line_clr = rd_line & (|line_flags);

  uart_irq_flags #(.W(ERR_W)) u_line_flags (
    .clk_i  (clk),
    .rst_ni (rst_sn),
    .set_i  (set_line_err),
    .clr_i  (line_clr),
    .q_o    (line_flags)
  );

  uart_irq_flags #(.W(DELTA_W)) u_modem_flags (
    .clk_i  (clk),
    .rst_ni (rst_sn),
    .set_i  (set_modem_delta),
    .clr_i  (rd_modem),
    .q_o    (modem_flags)
  );

  // ---------------- pending vector
  pend_t             pend_set, pend_clr, pend_q;
  logic [DATA_W-1:0] ident;

  always_comb begin
    pend_set            = '0;
    pend_set[SRC_RX]    = set_rx_avail | set_rx_timeout;
    pend_set[SRC_THR]   = set_thr_req | (wr_enable & reg_wdata[SRC_THR] & thr_empty);
    pend_set[SRC_LINE]  = |set_line_err;
    pend_set[SRC_MODEM] = |set_modem_delta;
    pend_set[SRC_TMO]   = set_rx_timeout;

    pend_clr            = '0;
    pend_clr[SRC_RX]    = clr_rx_avail;
    pend_clr[SRC_THR]   = clr_thr_req | (rd_ident & (ident[3:0] == IDENT_THR_NIB));
    pend_clr[SRC_LINE]  = line_clr;
    pend_clr[SRC_MODEM] = rd_modem;
    pend_clr[SRC_TMO]   = clr_rx_timeout | clr_rx_avail;
  end

  uart_irq_pending u_pending (
    .clk_i  (clk),
    .rst_ni (rst_sn),
    .set_i  (pend_set),
    .clr_i  (pend_clr),
    .pend_o (pend_q)
  );

  // ---------------- priority encode
  uart_irq_prio u_prio (
    .pend_i    (pend_q),
    .enab_i    (enab_q),
    .fifo_en_i (fifo_en),
    .irq_o     (irq),
    .ident_o   (ident)
  );

  // ---------------- read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENABLE: reg_rdata[NUM_SRC-1:0] = enab_q;
      A_IDENT:  reg_rdata              = ident;
      A_LINE:   reg_rdata[ERR_W:1]     = line_flags;
      A_MODEM:  reg_rdata[DELTA_W-1:0] = modem_flags;
      default:  reg_rdata              = '0;
    endcase
  end

  // ---------------- assertions
  assert_line_irq_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    ((|set_line_err) && enab_q[SRC_LINE] && !wr_enable) |=> irq);

  assert_ident_retire_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_ident && reg_rdata[3:0] == IDENT_THR_NIB && !set_thr_req && !reg_wr)
      |=> !pend_q[SRC_THR]);

  assert_enable_rearm_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_enable && reg_wdata[SRC_THR] && thr_empty) |=> (pend_q[SRC_THR] && irq));

  assert_enable_upper_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (reg_addr == A_ENABLE) |-> (reg_rdata[DATA_W-1:NUM_SRC] == '0));

  assert_line_clear_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_line && set_line_err == '0) |=> (line_flags == '0 && !pend_q[SRC_LINE]));

  assert_modem_clear_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_modem && set_modem_delta == '0) |=> (modem_flags == '0 && !pend_q[SRC_MODEM]));

  assert_fifo_off_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!fifo_en && reg_addr == A_IDENT) |-> (reg_rdata[7:6] == 2'b00 && !reg_rdata[3]));
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, thr_empty = 1'b0;
  logic       set_rx_avail = 1'b0, clr_rx_avail = 1'b0;
  logic       set_rx_timeout = 1'b0, clr_rx_timeout = 1'b0;
  logic       set_thr_req = 1'b0, clr_thr_req = 1'b0;
  logic [3:0] set_line_err = 4'h0, set_modem_delta = 4'h0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_empty(thr_empty),
    .set_rx_avail(set_rx_avail), .clr_rx_avail(clr_rx_avail),
    .set_rx_timeout(set_rx_timeout), .clr_rx_timeout(clr_rx_timeout),
    .set_thr_req(set_thr_req), .clr_thr_req(clr_thr_req),
    .set_line_err(set_line_err), .set_modem_delta(set_modem_delta),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run reached %0d cycles, expected completion earlier", cyc);
      report();
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    set_rx_avail = 0; clr_rx_avail = 0; set_rx_timeout = 0; clr_rx_timeout = 0;
    set_thr_req = 0; clr_thr_req = 0; set_line_err = 0; set_modem_delta = 0;
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_strobe(input logic [2:0] a);
    reg_addr = a; reg_rd = 1; tick(); reg_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic clear_all();
    clr_rx_avail = 1; clr_thr_req = 1;
    rd_strobe(3'd5);
    clr_rx_avail = 0; clr_thr_req = 0;
    rd_strobe(3'd6);
  endtask

  logic [7:0] got, exp;
  logic [3:0] p, act;
  logic [2:0] code;
  string      tag;

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // reset state
    peek(3'd2, got); check("R2 reset ident", got, 8'h01);
    peek(3'd1, got); check("R2 reset enable", got, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);

    // sweep: pending conditions x enable x FIFO mode
    for (int fe = 0; fe < 2; fe++) begin
      fifo_en = fe[0];
      for (int m = 0; m < 32; m++) begin
        for (int e = 0; e < 16; e++) begin
          clear_all();
          wr(3'd1, 8'(e));
          set_rx_avail    = m[0];
          set_thr_req     = m[1];
          set_line_err    = m[2] ? 4'b0100 : 4'b0000;
          set_modem_delta = m[3] ? 4'b1000 : 4'b0000;
          set_rx_timeout  = m[4];
          tick();
          idle();
          p = m[3:0];
          if (m[4]) p[0] = 1'b1;
          act = p & e[3:0];
          if (act[2])      code = 3'b011;
          else if (act[0]) code = (m[4] && fe == 1) ? 3'b110 : 3'b010;
          else if (act[1]) code = 3'b001;
          else             code = 3'b000;
          exp = {{2{fe[0]}}, 2'b00, code, ~(|act)};
          if (code == 3'b110)          tag = "R4 timeout code";
          else if (fe == 0)            tag = "R10 fifo off ident";
          else                         tag = "R3 priority ident";
          peek(3'd2, got); check(tag, got, exp);
          check("R1 irq level", {7'b0, irq}, {7'b0, |act});
        end
      end
    end

    fifo_en = 1'b1;
    // R5: identification read retires transmit source
    clear_all(); wr(3'd1, 8'h02);
    set_thr_req = 1; tick(); idle();
    peek(3'd2, got); check("R5 thr shown", got, 8'hC2);
    rd_strobe(3'd2);
    peek(3'd2, got); check("R5 thr retired", got, 8'hC1);
    check("R5 irq low", {7'b0, irq}, 8'h00);
    // R5: read while line error showing keeps transmit source
    clear_all(); wr(3'd1, 8'h06);
    set_thr_req = 1; set_line_err = 4'b0010; tick(); idle();
    peek(3'd2, got); check("R5 line over thr", got, 8'hC6);
    rd_strobe(3'd2);
    peek(3'd2, got); check("R5 thr kept", got, 8'hC6);
    rd_strobe(3'd5);
    peek(3'd2, got); check("R5 thr after line clear", got, 8'hC2);

    // R6: enable rewrite re-arms transmit source only when empty
    clear_all(); thr_empty = 1;
    wr(3'd1, 8'h02);
    check("R6 rearm irq", {7'b0, irq}, 8'h01);
    thr_empty = 0; clear_all();
    wr(3'd1, 8'h02);
    check("R6 no rearm", {7'b0, irq}, 8'h00);

    // R7 / R12
    wr(3'd1, 8'hFF);
    peek(3'd1, got); check("R7 enable readback", got, 8'h0F);
    wr(3'd3, 8'h00); wr(3'd7, 8'h00);
    peek(3'd1, got); check("R12 foreign write ignored", got, 8'h0F);
    peek(3'd0, got); check("R12 addr0", got, 8'h00);
    peek(3'd3, got); check("R12 addr3", got, 8'h00);
    peek(3'd4, got); check("R12 addr4", got, 8'h00);
    peek(3'd7, got); check("R12 addr7", got, 8'h00);

    // R8: line error flags
    clear_all(); wr(3'd1, 8'h04);
    set_line_err = 4'b1010; tick(); idle();
    peek(3'd5, got); check("R8 flags", got, 8'h14);
    check("R8 irq", {7'b0, irq}, 8'h01);
    rd_strobe(3'd5);
    peek(3'd5, got); check("R8 flags cleared", got, 8'h00);
    check("R8 irq cleared", {7'b0, irq}, 8'h00);

    // R9: modem deltas
    wr(3'd1, 8'h08);
    set_modem_delta = 4'b0101; tick(); idle();
    peek(3'd6, got); check("R9 deltas", got, 8'h05);
    peek(3'd2, got); check("R9 modem code", got, 8'hC0);
    rd_strobe(3'd6);
    peek(3'd6, got); check("R9 deltas cleared", got, 8'h00);
    check("R9 irq cleared", {7'b0, irq}, 8'h00);

    // R4: timeout clear paths
    clear_all(); wr(3'd1, 8'h01);
    set_rx_timeout = 1; tick(); idle();
    peek(3'd2, got); check("R4 timeout", got, 8'hCC);
    clr_rx_timeout = 1; tick(); idle();
    peek(3'd2, got); check("R4 timeout withdrawn", got, 8'hC4);
    clr_rx_avail = 1; tick(); idle();
    peek(3'd2, got); check("R4 data drained", got, 8'hC1);

    // R10: FIFO mode off hides timeout bit
    set_rx_timeout = 1; tick(); idle();
    fifo_en = 0;
    peek(3'd2, got); check("R10 fifo off", got, 8'h04);
    fifo_en = 1;
    peek(3'd2, got); check("R10 fifo on", got, 8'hCC);

    // R11: set and clear together
    clear_all(); wr(3'd1, 8'h02);
    set_thr_req = 1; clr_thr_req = 1; tick(); idle();
    check("R11 set wins", {7'b0, irq}, 8'h01);

    report();
  end
endmodule